// File: doc/BRIEF.md
# Converter Fault and Hiccup Sequencer

This block supervises a multiphase buck converter from the moment power-on reset is released. It generates a digital soft-start ramp. The PWM stage uses that ramp to clamp both pulse width and the output reference. The block also compares the digitized output voltage against the reference code to detect over-voltage and to drive an open-drain-style power-good signal. Comparisons work on codes only; the analog-to-digital conversion happens elsewhere.

When any phase reports over-current, the sequencer tri-states every PWM output and runs a hiccup cycle. The ramp keeps charging up to a high threshold, then discharges down to a low threshold, and the converter then restarts. Each over-current event counts as a strike, and only power-on reset clears the count. On the third strike the converter is shut down for good. Over-voltage forces every PWM output low and holds that state until the next power-on reset. While the reference is moving between targets, power-good keeps its current value.

Top module: `faultSequencer`

## Requirements
- R1: While `porN` is low, and on the first cycle after it rises, `ssClamp` is 0, `pwmMode` is 2'b00 (normal), `pgoodOd` is 0, `ovFlag` is 0 and `disabled` is 0.
- R2: In the run state, `ssClamp` grows by SS_STEP once every PRESC_DIV cycles, and saturates at 2^SS_W-1. The first increment follows the PRESC_DIV-th rising edge after reset release.
- R3: Over-voltage is detected in the run or hiccup states when `vRefCode` is nonzero and 100*vOut >= OV_PCT*vRef (default 140%). From the next edge, `ovFlag` is 1 and `pwmMode` is 2'b01 (forced low). One cycle later, `ssClamp` is 0. All of this holds until power-on reset, whatever the inputs do.
- R4: When over-voltage and over-current are both detected in the same cycle, over-voltage wins and no strike is counted.
- R5: `pgoodOd` is registered. It becomes 1 only if, on the previous edge, the block was in the run state and 100*vOut >= PG_PCT*vRef (default 92%). It is 0 after any edge taken outside the run state.
- R6: In the run state, while `refMoving` is 1, `pgoodOd` keeps its value on every edge.
- R7: Any bit of `ocFlags` set in the run state makes `pwmMode` 2'b10 (tri-state) from the next edge, counts one strike and starts a hiccup.
- R8: During a hiccup, the ramp keeps rising until it reaches 90% of full scale. It then falls by SS_STEP per prescaler tick until it is below 4% of full scale (0.2/5). At that point the run state and `pwmMode` 2'b00 resume, and the ramp rises from its current value. `ocFlags` has no effect during a hiccup.
- R9: The strike count survives a restart. The MAX_STRIKES-th strike (default 3) sets `disabled` to 1 with `pwmMode` 2'b10, then clears the ramp. After that the block ignores over-current and over-voltage until power-on reset.
- R10: Power-on reset clears the over-voltage latch, the disabled latch and the strike count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| vOutCode | input | CODE_W | Digitized output voltage |
| vRefCode | input | CODE_W | Reference voltage code |
| ocFlags | input | NUM_CH | Per-phase over-current flags |
| refMoving | input | 1 | Reference transition in progress |
| ssClamp | output | SS_W | Soft-start ramp value |
| pwmMode | output | 2 | 00 normal, 01 forced low, 10 tri-state |
| pgoodOd | output | 1 | Power-good, 0 means pulled low |
| ovFlag | output | 1 | Over-voltage latch |
| disabled | output | 1 | Converter shut down after final strike |

## Verification
The bench builds the block with an 8-bit ramp, a step of 16 and a prescaler of 2. With these values a full ramp takes 32 cycles and a hiccup drains in about as many, so several complete strike and restart rounds, and the final lockout, fit in a short run. The 8-bit codes with a reference of 100 place the 92% and 140% boundaries on exact integers (92 and 140), so the bench can probe each threshold one code on either side.

// File: rtl/fseqPkg.sv
package fseqPkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_HIC_UP = 3'd1,
    ST_HIC_DN = 3'd2,
    ST_OV     = 3'd3,
    ST_DIS    = 3'd4
  } seqState_t;

  typedef enum logic [1:0] {
    PWM_NORMAL = 2'b00,
    PWM_LOW    = 2'b01,
    PWM_HIZ    = 2'b10
  } pwmMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic rampUp;
    logic rampDown;
    logic rampClr;
    logic pgEnable;
  } dpCtrl_t;

  // datapath -> control observations
  typedef struct packed {
    logic ovDet;
    logic ocDet;
    logic rampHigh;
    logic rampLow;
  } dpStat_t;

endpackage

// File: rtl/fseqDatapath.sv
module fseqDatapath
  import fseqPkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int NUM_CH    = 4,
  parameter int SS_W      = 10,
  parameter int SS_STEP   = 4,
  parameter int PRESC_DIV = 64,
  parameter int OV_PCT    = 140,
  parameter int PG_PCT    = 92
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [CODE_W-1:0] vOutCode,
  input  logic [CODE_W-1:0] vRefCode,
  input  logic [NUM_CH-1:0] ocFlags,
  input  logic              refMoving,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat,
  output logic [SS_W-1:0]   ssClamp,
  output logic              pgoodOd
);

  localparam int FULL_SCALE = (1 << SS_W) - 1;
  localparam int HI_THR     = (FULL_SCALE * 9) / 10;
  localparam int LO_THR     = (FULL_SCALE * 2) / 50;
  localparam int PW         = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int MW         = CODE_W + 8;

  logic tick;

  generate
    if (PRESC_DIV <= 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] prescCnt;
      always_ff @(posedge clk or negedge porN) begin
        if (!porN)      prescCnt <= '0;
        else if (tick)  prescCnt <= '0;
        else            prescCnt <= prescCnt + PW'(1);
      end
      assign tick = (prescCnt == PW'(PRESC_DIV - 1));
    end
  endgenerate

  // ramp arithmetic
  logic [SS_W:0]   upSum;
  logic [SS_W-1:0] rampUpV, rampDnV, ramp;

  always_comb begin
    upSum   = {1'b0, ramp} + (SS_W+1)'(SS_STEP);
    rampUpV = (upSum > (SS_W+1)'(FULL_SCALE)) ? SS_W'(FULL_SCALE) : upSum[SS_W-1:0];
    rampDnV = (ramp > SS_W'(SS_STEP)) ? (ramp - SS_W'(SS_STEP)) : '0;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                        ramp <= '0;
    else if (ctrl.rampClr)            ramp <= '0;
    else if (tick && ctrl.rampUp)     ramp <= rampUpV;
    else if (tick && ctrl.rampDown)   ramp <= rampDnV;
  end

  // percentage compares on codes
  logic [MW-1:0] outScaled, ovLimit, pgLimit;
  logic          pgCmp;

  always_comb begin
    outScaled = MW'(vOutCode) * MW'(100);
    ovLimit   = MW'(vRefCode) * MW'(OV_PCT);
    pgLimit   = MW'(vRefCode) * MW'(PG_PCT);
    pgCmp     = (outScaled >= pgLimit);
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              pgoodOd <= 1'b0;
    else if (!ctrl.pgEnable) pgoodOd <= 1'b0;
    else if (!refMoving)    pgoodOd <= pgCmp;
  end

  assign stat.ovDet    = (vRefCode != '0) && (outScaled >= ovLimit);
  assign stat.ocDet    = |ocFlags;
  assign stat.rampHigh = (ramp >= SS_W'(HI_THR));
  assign stat.rampLow  = (ramp <  SS_W'(LO_THR));
  assign ssClamp       = ramp;

endmodule

// File: rtl/fseqControl.sv
module fseqControl
  import fseqPkg::*;
#(
  parameter int MAX_STRIKES = 3
) (
  input  logic     clk,
  input  logic     porN,
  input  dpStat_t  stat,
  output dpCtrl_t  ctrl,
  output pwmMode_t modeSel,
  output logic     ovLatched,
  output logic     disLatched
);

  localparam int SK_W = $clog2(MAX_STRIKES + 1);

  seqState_t       state, nxtState;
  logic [SK_W-1:0] strikes, nxtStrikes;

  always_comb begin
    nxtState   = state;
    nxtStrikes = strikes;
    case (state)
      ST_RUN: begin
        if (stat.ovDet) nxtState = ST_OV;
        else if (stat.ocDet) begin
          nxtStrikes = strikes + SK_W'(1);
          nxtState   = (nxtStrikes == SK_W'(MAX_STRIKES)) ? ST_DIS : ST_HIC_UP;
        end
      end
      ST_HIC_UP: begin
        if (stat.ovDet)         nxtState = ST_OV;
        else if (stat.rampHigh) nxtState = ST_HIC_DN;
      end
      ST_HIC_DN: begin
        if (stat.ovDet)        nxtState = ST_OV;
        else if (stat.rampLow) nxtState = ST_RUN;
      end
      default: nxtState = state;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state   <= ST_RUN;
      strikes <= '0;
    end else begin
      state   <= nxtState;
      strikes <= nxtStrikes;
    end
  end

  always_comb begin
    ctrl.rampUp   = (state == ST_RUN) || (state == ST_HIC_UP);
    ctrl.rampDown = (state == ST_HIC_DN);
    ctrl.rampClr  = (state == ST_OV) || (state == ST_DIS);
    ctrl.pgEnable = (state == ST_RUN);
    case (state)
      ST_RUN:  modeSel = PWM_NORMAL;
      ST_OV:   modeSel = PWM_LOW;
      default: modeSel = PWM_HIZ;
    endcase
    ovLatched  = (state == ST_OV);
    disLatched = (state == ST_DIS);
  end

endmodule

// File: rtl/faultSequencer.sv
module faultSequencer
  import fseqPkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int NUM_CH      = 4,
  parameter int SS_W        = 10,
  parameter int SS_STEP     = 4,
  parameter int PRESC_DIV   = 64,
  parameter int MAX_STRIKES = 3,
  parameter int OV_PCT      = 140,
  parameter int PG_PCT      = 92
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [CODE_W-1:0] vOutCode,
  input  logic [CODE_W-1:0] vRefCode,
  input  logic [NUM_CH-1:0] ocFlags,
  input  logic              refMoving,
  output logic [SS_W-1:0]   ssClamp,
  output logic [1:0]        pwmMode,
  output logic              pgoodOd,
  output logic              ovFlag,
  output logic              disabled
);

  dpCtrl_t  ctrl;
  dpStat_t  stat;
  pwmMode_t modeSel;

  fseqDatapath #(
    .CODE_W(CODE_W), .NUM_CH(NUM_CH), .SS_W(SS_W), .SS_STEP(SS_STEP),
    .PRESC_DIV(PRESC_DIV), .OV_PCT(OV_PCT), .PG_PCT(PG_PCT)
  ) u_dp (
    .clk(clk), .porN(porN), .vOutCode(vOutCode), .vRefCode(vRefCode),
    .ocFlags(ocFlags), .refMoving(refMoving), .ctrl(ctrl), .stat(stat),
    .ssClamp(ssClamp), .pgoodOd(pgoodOd)
  );

  fseqControl #(.MAX_STRIKES(MAX_STRIKES)) u_ctl (
    .clk(clk), .porN(porN), .stat(stat), .ctrl(ctrl), .modeSel(modeSel),
    .ovLatched(ovFlag), .disLatched(disabled)
  );

  assign pwmMode = modeSel;

endmodule

// File: rtl/faultSequencerChecker.sv
module faultSequencerChecker #(
  parameter int SS_W = 10
) (
  input logic            clk,
  input logic            porN,
  input logic            refMoving,
  input logic [SS_W-1:0] ssClamp,
  input logic [1:0]      pwmMode,
  input logic            pgoodOd,
  input logic            ovFlag,
  input logic            disabled
);

  // R3
  ov_latch_chk: assert property (@(posedge clk) disable iff (!porN)
    ovFlag |=> ovFlag);

  // R3
  ov_mode_chk: assert property (@(posedge clk) disable iff (!porN)
    ovFlag |-> (pwmMode == 2'b01));

  // R9
  dis_latch_chk: assert property (@(posedge clk) disable iff (!porN)
    disabled |=> (disabled && pwmMode == 2'b10));

  // R6
  pg_freeze_chk: assert property (@(posedge clk) disable iff (!porN)
    (refMoving && pwmMode == 2'b00) |=> $stable(pgoodOd));

  // R5
  pg_fault_low_chk: assert property (@(posedge clk) disable iff (!porN)
    (pwmMode != 2'b00) |=> !pgoodOd);

  // R2
  ramp_mono_chk: assert property (@(posedge clk) disable iff (!porN)
    (pwmMode == 2'b00) |=> (ssClamp >= $past(ssClamp)));

  // R9
  latch_excl_chk: assert property (@(posedge clk) disable iff (!porN)
    $onehot0({ovFlag, disabled}));

endmodule

bind faultSequencer faultSequencerChecker #(.SS_W(SS_W)) u_chk (
  .clk(clk), .porN(porN), .refMoving(refMoving), .ssClamp(ssClamp),
  .pwmMode(pwmMode), .pgoodOd(pgoodOd), .ovFlag(ovFlag), .disabled(disabled)
);

// File: tb/faultSequencer_bench.sv
module faultSequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW    = 8;
  localparam int NCH   = 4;
  localparam int SW    = 8;
  localparam int STEP  = 16;
  localparam int PDIV  = 2;
  localparam int MAXS  = 3;
  localparam int FULL  = 255;
  localparam int HITH  = (FULL * 9) / 10;
  localparam int LOTH  = (FULL * 2) / 50;

  logic           clk = 1'b0;
  logic           porN = 1'b0;
  logic [CW-1:0]  vOutCode = '0;
  logic [CW-1:0]  vRefCode = '0;
  logic [NCH-1:0] ocFlags = '0;
  logic           refMoving = 1'b0;
  logic [SW-1:0]  ssClamp;
  logic [1:0]     pwmMode;
  logic           pgoodOd, ovFlag, disabled;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  bit    cmpEn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  faultSequencer #(
    .CODE_W(CW), .NUM_CH(NCH), .SS_W(SW), .SS_STEP(STEP),
    .PRESC_DIV(PDIV), .MAX_STRIKES(MAXS), .OV_PCT(140), .PG_PCT(92)
  ) u_faultSequencer (
    .clk(clk), .porN(porN), .vOutCode(vOutCode), .vRefCode(vRefCode),
    .ocFlags(ocFlags), .refMoving(refMoving), .ssClamp(ssClamp),
    .pwmMode(pwmMode), .pgoodOd(pgoodOd), .ovFlag(ovFlag), .disabled(disabled)
  );

  // behavioural reference: phase 0 run, 1 hiccup rising, 2 hiccup falling, 3 over-voltage, 4 off
  int mPhase = 0, mRamp = 0, mStrikes = 0, mPg = 0, mCnt = 0;

  always @(posedge clk) begin
    if (!porN) begin
      mPhase = 0; mRamp = 0; mStrikes = 0; mPg = 0; mCnt = 0;
    end else begin
      bit tk, ov, oc;
      int nRamp, nPg, nPhase;
      tk = (mCnt == PDIV - 1);
      mCnt = tk ? 0 : mCnt + 1;
      ov = (vRefCode != 0) && (int'(vOutCode) * 100 >= int'(vRefCode) * 140);
      oc = (ocFlags != 0);
      nRamp = mRamp;
      if (mPhase >= 3) nRamp = 0;
      else if (tk && mPhase < 2) nRamp = (mRamp + STEP > FULL) ? FULL : mRamp + STEP;
      else if (tk) nRamp = (mRamp > STEP) ? mRamp - STEP : 0;
      if (mPhase != 0) nPg = 0;
      else if (refMoving) nPg = mPg;
      else nPg = (int'(vOutCode) * 100 >= int'(vRefCode) * 92) ? 1 : 0;
      nPhase = mPhase;
      if (mPhase < 3 && ov) nPhase = 3;
      else if (mPhase == 0 && oc) begin
        mStrikes++;
        nPhase = (mStrikes >= MAXS) ? 4 : 1;
      end else if (mPhase == 1 && mRamp >= HITH) nPhase = 2;
      else if (mPhase == 2 && mRamp < LOTH) nPhase = 0;
      mRamp = nRamp; mPg = nPg; mPhase = nPhase;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpEn && porN) begin
      int expMode;
      expMode = (mPhase == 0) ? 0 : (mPhase == 3) ? 1 : 2;
      check(curReq, "model ssClamp", int'(ssClamp), mRamp);
      check(curReq, "model pwmMode", int'(pwmMode), expMode);
      check(curReq, "model pgoodOd", int'(pgoodOd), mPg);
      check(curReq, "model ovFlag", int'(ovFlag), (mPhase == 3) ? 1 : 0);
      check(curReq, "model disabled", int'(disabled), (mPhase == 4) ? 1 : 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ocPulse(input logic [NCH-1:0] f);
    ocFlags = f;
    cyc(1);
    ocFlags = '0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1 reset state
    cyc(3);
    check("R1", "ssClamp", int'(ssClamp), 0);
    check("R1", "pwmMode", int'(pwmMode), 0);
    check("R1", "pgoodOd", int'(pgoodOd), 0);
    check("R1", "ovFlag", int'(ovFlag), 0);
    check("R1", "disabled", int'(disabled), 0);
    porN = 1'b1;
    cmpEn = 1'b1;
    vRefCode = 8'd100;
    vOutCode = 8'd50;
    cyc(1);
    check("R1", "ssClamp after release", int'(ssClamp), 0);

    // R2 ramp rises and saturates
    curReq = "R2";
    cyc(40);
    check("R2", "ramp saturated", int'(ssClamp), FULL);

    // R5 power-good thresholds
    curReq = "R5";
    vOutCode = 8'd95; cyc(2);
    check("R5", "pg above", int'(pgoodOd), 1);
    vOutCode = 8'd91; cyc(2);
    check("R5", "pg 91pct", int'(pgoodOd), 0);
    vOutCode = 8'd92; cyc(2);
    check("R5", "pg 92pct", int'(pgoodOd), 1);

    // R6 freeze during reference transition
    curReq = "R6";
    vOutCode = 8'd91; cyc(2);
    refMoving = 1'b1; vOutCode = 8'd95; cyc(5);
    check("R6", "pg frozen low", int'(pgoodOd), 0);
    refMoving = 1'b0; cyc(2);
    check("R6", "pg after transition", int'(pgoodOd), 1);
    refMoving = 1'b1; vOutCode = 8'd50; cyc(4);
    check("R6", "pg frozen high", int'(pgoodOd), 1);
    refMoving = 1'b0; vOutCode = 8'd95; cyc(2);

    // R7 over-current enters hiccup
    curReq = "R7";
    ocPulse(4'b0100);
    check("R7", "tri-state", int'(pwmMode), 2);
    cyc(1);
    check("R7", "pg dropped", int'(pgoodOd), 0);

    // R8 hiccup drain, ignored over-current, restart
    curReq = "R8";
    cyc(4);
    ocPulse(4'b0001);
    cyc(10);
    check("R8", "still hiccup", int'(pwmMode), 2);
    cyc(70);
    check("R8", "restarted", int'(pwmMode), 0);
    check("R8", "ramp refilled", int'(ssClamp), FULL);

    // R3 boundary just below trip
    curReq = "R3";
    vOutCode = 8'd139; cyc(2);
    check("R3", "no trip at 139", int'(ovFlag), 0);

    // R4 simultaneous over-voltage and over-current
    curReq = "R4";
    vOutCode = 8'd140;
    ocPulse(4'b1000);
    check("R4", "ov wins", int'(ovFlag), 1);
    check("R4", "forced low", int'(pwmMode), 1);
    curReq = "R3";
    vOutCode = 8'd0; cyc(10);
    check("R3", "ov latched", int'(ovFlag), 1);
    check("R3", "ramp cleared", int'(ssClamp), 0);
    check("R3", "mode held", int'(pwmMode), 1);

    // R10 power-on reset clears latches
    curReq = "R10";
    porN = 1'b0; cyc(1);
    porN = 1'b1; vOutCode = 8'd95; cyc(1);
    check("R10", "ov cleared", int'(ovFlag), 0);
    check("R10", "mode normal", int'(pwmMode), 0);
    cyc(40);

    // R9 strikes persist across restarts, third one locks out
    curReq = "R9";
    for (int s = 0; s < 2; s++) begin
      ocPulse(4'b0010);
      check("R9", "hiccup strike", int'(pwmMode), 2);
      cyc(80);
      check("R9", "restart after strike", int'(pwmMode), 0);
    end
    ocPulse(4'b0010);
    check("R9", "disabled", int'(disabled), 1);
    check("R9", "tri-state when off", int'(pwmMode), 2);
    vOutCode = 8'd200; cyc(5);
    check("R9", "ov ignored", int'(ovFlag), 0);
    check("R9", "still off", int'(disabled), 1);
    check("R9", "ramp cleared", int'(ssClamp), 0);

    curReq = "R10";
    porN = 1'b0; cyc(1);
    porN = 1'b1; vOutCode = 8'd95; cyc(2);
    check("R10", "disabled cleared", int'(disabled), 0);
    check("R10", "mode normal", int'(pwmMode), 0);
    ocPulse(4'b0001);
    check("R10", "strikes cleared", int'(disabled), 0);
    cyc(5);
    summary();
  end

endmodule